// File: doc/BRIEF.md
# Reconfigurable Loop-Array Cell Fabric

The fabric is a two-dimensional grid of cell slots joined by a serial data bus. Each slot has up to four boundary multiplexor stages, numbered from the highest index down to 1. The cell sends into the highest-index stage and receives from stage 1. Each stage either passes the slot's own loop signal or takes the signal that feeds the stage of the same index in the adjacent slot. When two adjacent slots both switch that stage, their two loops merge into one. A tree of such links therefore forms a single loop through every slot it touches. Every stage is registered, so a token from one cell reaches the next cell in the loop after exactly NMUX cycles, whatever the routing.

The routing is set by a shift chain of NMUX bits per slot. A separate load strobe copies the chain into the active controls, so the routing never changes while new bits are being shifted. After reset all active controls are clear, and each slot is a closed loop that holds only itself. Setting NMUX to 3 removes the highest-index stage and gives the three-neighbour variant. Slots on the grid boundary ignore the control bits of stages that face outward.

Top module: `loop_fabric`

## Requirements
- R1: After reset every active control bit is 0 and the readback output is 0. A token sent by any slot is received by that same slot and by no other.
- R2: In any routing, a token sent by one cell reaches exactly one cell, exactly NMUX clock cycles later.
- R3: The link between two adjacent slots is used only when both equal-index stage bits are 1. If only one of the two bits is set, both slots keep their own paths.
- R4: A stage whose side faces the grid boundary passes its own loop signal whatever its control bit holds.
- R5: While cfg_shift_en is high, every clock moves the chain one place toward bit 0, and cfg_sdi enters at the top bit. cfg_sdo always shows bit 0. Slot s (s = row*COLS + col) keeps the control bit for stage k at chain bit s*NMUX + k-1.
- R6: Shifting the chain without cfg_load leaves the active routing unchanged.
- R7: A cycle with cfg_load high copies the whole chain into the active controls at that clock edge.
- R8: Stage faces are fixed by slot parity. When (row+col) is even, stage 4 faces north, 3 east, 2 south and 1 west. When it is odd, stage 4 faces south, 3 west, 2 north and 1 east. If the active links form a tree, a token passed from cell to cell visits every slot of that tree exactly once before it returns to its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_shift_en | input | 1 | Shifts the configuration chain by one place |
| cfg_sdi | input | 1 | Serial configuration bit that enters the chain |
| cfg_load | input | 1 | Copies the chain into the active controls |
| cfg_sdo | output | 1 | Chain readback (bit 0) |
| cell_tx | input | ROWS*COLS*W | Per-slot data sent into the loop, slot s at bits s*W |
| cell_rx | output | ROWS*COLS*W | Per-slot data received from the loop, slot s at bits s*W |

## Verification
On every cycle, the assertions check how the configuration chain shifts and reads back, that the active controls hold until a load and that a load copies the chain, and that the controls stay clear until the first load after reset. What only the bench's scenarios can show is how tokens walk through the data path. These scenarios cover isolated slots after reset, single- and multi-component trees, one-sided and boundary-facing control bits, and a routing that stays live while a new image is shifted in. Each hop's latency and each slot's visit count are compared with a grid model kept in the bench.

// File: rtl/loop_fabric_pkg.sv
package loop_fabric_pkg;

  typedef enum logic [1:0] {
    FACE_N = 2'd0,
    FACE_E = 2'd1,
    FACE_S = 2'd2,
    FACE_W = 2'd3
  } face_e;

  // Side a stage faces, from slot parity and stage index (1..4)
  function automatic face_e stage_face(input int par, input int k);
    case (k)
      4:       return (par != 0) ? FACE_S : FACE_N;
      3:       return (par != 0) ? FACE_W : FACE_E;
      2:       return (par != 0) ? FACE_N : FACE_S;
      default: return (par != 0) ? FACE_E : FACE_W;
    endcase
  endfunction

  function automatic int face_drow(input face_e f);
    return (f == FACE_N) ? -1 : ((f == FACE_S) ? 1 : 0);
  endfunction

  function automatic int face_dcol(input face_e f);
    return (f == FACE_W) ? -1 : ((f == FACE_E) ? 1 : 0);
  endfunction

endpackage

// File: rtl/loop_cfg_chain.sv
module loop_cfg_chain #(
  parameter int TOT = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           sdi,
  input  logic           load,
  output logic           sdo,
  output logic [TOT-1:0] shadow,
  output logic [TOT-1:0] act
);

  logic [TOT-1:0] shadow_q, shadow_d;
  logic [TOT-1:0] act_q, act_d;

  always_comb begin
    shadow_d = shadow_q;
    if (shift_en) shadow_d = {sdi, shadow_q[TOT-1:1]};
  end

  always_comb begin
    act_d = act_q;
    if (load) act_d = shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      act_q    <= '0;
    end else begin
      shadow_q <= shadow_d;
      act_q    <= act_d;
    end
  end

  assign sdo    = shadow_q[0];
  assign shadow = shadow_q;
  assign act    = act_q;

endmodule

// File: rtl/loop_pair_map.sv
module loop_pair_map
  import loop_fabric_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int NMUX = 4,
  parameter int W    = 8,
  localparam int NSLOT = ROWS * COLS,
  localparam int TOT   = NSLOT * NMUX
) (
  input  logic [TOT-1:0]   act,
  input  logic [TOT*W-1:0] own_all,
  output logic [TOT-1:0]   sel,
  output logic [TOT*W-1:0] nbr_all
);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam int R   = s / COLS;
    localparam int C   = s % COLS;
    localparam int PAR = (R + C) % 2;
    for (genvar k = 1; k <= NMUX; k++) begin : g_stage
      localparam face_e F  = stage_face(PAR, k);
      localparam int    NR = R + face_drow(F);
      localparam int    NC = C + face_dcol(F);
      localparam int    ME = s * NMUX + k - 1;
      if (NR >= 0 && NR < ROWS && NC >= 0 && NC < COLS) begin : g_link
        localparam int PEER = (NR * COLS + NC) * NMUX + k - 1;
        assign sel[ME]            = act[ME] & act[PEER];
        assign nbr_all[ME*W +: W] = own_all[PEER*W +: W];
      end else begin : g_edge
        assign sel[ME]            = 1'b0;
        assign nbr_all[ME*W +: W] = '0;
      end
    end
  end

endmodule

// File: rtl/loop_slot.sv
module loop_slot #(
  parameter int NMUX = 4,
  parameter int W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      tx,
  input  logic [NMUX-1:0]   sel,
  input  logic [NMUX*W-1:0] nbr_in,
  output logic [NMUX*W-1:0] own_out,
  output logic [W-1:0]      rx
);

  logic [W-1:0] st_q [NMUX];
  logic [W-1:0] st_d [NMUX];
  logic [W-1:0] own  [NMUX];

  // Stage k-1 index holds the registered output of mux m(k)
  for (genvar k = 0; k < NMUX; k++) begin : g_feed
    if (k == NMUX - 1) begin : g_top
      assign own[k] = tx;
    end else begin : g_mid
      assign own[k] = st_q[k+1];
    end
    assign own_out[k*W +: W] = own[k];
  end

  always_comb begin
    for (int k = 0; k < NMUX; k++) begin
      st_d[k] = sel[k] ? nbr_in[k*W +: W] : own[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NMUX; k++) st_q[k] <= '0;
    end else begin
      for (int k = 0; k < NMUX; k++) st_q[k] <= st_d[k];
    end
  end

  assign rx = st_q[0];

endmodule

// File: rtl/loop_fabric.sv
module loop_fabric #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int NMUX = 4,
  parameter int W    = 8,
  localparam int NSLOT = ROWS * COLS,
  localparam int TOT   = NSLOT * NMUX
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_shift_en,
  input  logic               cfg_sdi,
  input  logic               cfg_load,
  output logic               cfg_sdo,
  input  logic [NSLOT*W-1:0] cell_tx,
  output logic [NSLOT*W-1:0] cell_rx
);

  logic [TOT-1:0]   cfg_shadow;
  logic [TOT-1:0]   act_ctrl;
  logic [TOT-1:0]   sel_all;
  logic [TOT*W-1:0] own_all;
  logic [TOT*W-1:0] nbr_all;

  loop_cfg_chain #(.TOT(TOT)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_shift_en),
    .sdi      (cfg_sdi),
    .load     (cfg_load),
    .sdo      (cfg_sdo),
    .shadow   (cfg_shadow),
    .act      (act_ctrl)
  );

  loop_pair_map #(.ROWS(ROWS), .COLS(COLS), .NMUX(NMUX), .W(W)) u_map (
    .act     (act_ctrl),
    .own_all (own_all),
    .sel     (sel_all),
    .nbr_all (nbr_all)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    loop_slot #(.NMUX(NMUX), .W(W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .tx      (cell_tx[s*W +: W]),
      .sel     (sel_all[s*NMUX +: NMUX]),
      .nbr_in  (nbr_all[s*NMUX*W +: NMUX*W]),
      .own_out (own_all[s*NMUX*W +: NMUX*W]),
      .rx      (cell_rx[s*W +: W])
    );
  end

endmodule

// File: rtl/loop_fabric_chk.sv
module loop_fabric_chk #(
  parameter int TOT = 64
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_shift_en,
  input logic           cfg_load,
  input logic           cfg_sdo,
  input logic [TOT-1:0] shadow,
  input logic [TOT-1:0] act
);

  logic seen_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen_load <= 1'b0;
    else if (cfg_load) seen_load <= 1'b1;
  end

  // R1
  default_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_load |-> (act == '0));

  // R5
  shift_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_shift_en |=> (cfg_sdo == $past(shadow[1])));

  // R5
  chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_shift_en |=> $stable(shadow));

  // R6
  route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(act));

  // R7
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (act == $past(shadow)));

endmodule

bind loop_fabric loop_fabric_chk #(.TOT(TOT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_shift_en (cfg_shift_en),
  .cfg_load     (cfg_load),
  .cfg_sdo      (cfg_sdo),
  .shadow       (cfg_shadow),
  .act          (act_ctrl)
);

// File: tb/loop_fabric_test.sv
`timescale 1ns/1ps
module loop_fabric_test;
  localparam int ROWS  = 3;
  localparam int COLS  = 4;
  localparam int NMUX  = 4;
  localparam int W     = 8;
  localparam int NSLOT = ROWS * COLS;
  localparam int TOT   = NSLOT * NMUX;
  localparam logic [W-1:0] TOKEN = 8'h5A;

  logic clk = 1'b0;
  logic rst_n, cfg_shift_en, cfg_sdi, cfg_load;
  logic cfg_sdo;
  logic [NSLOT*W-1:0] cell_tx, cell_rx;

  int checks = 0, failures = 0;
  logic [TOT-1:0] work, live;

  always #4 clk = ~clk;

  loop_fabric #(.ROWS(ROWS), .COLS(COLS), .NMUX(NMUX), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_shift_en(cfg_shift_en), .cfg_sdi(cfg_sdi),
    .cfg_load(cfg_load), .cfg_sdo(cfg_sdo), .cell_tx(cell_tx), .cell_rx(cell_rx)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act_v, exp_v);
    end
  endtask

  // Geometry per R8: dir 0=N 1=E 2=S 3=W
  function automatic int kfor(input int par, input int d);
    if (par == 0) return (d == 0) ? 4 : (d == 1) ? 3 : (d == 2) ? 2 : 1;
    return (d == 2) ? 4 : (d == 3) ? 3 : (d == 0) ? 2 : 1;
  endfunction

  function automatic int nbr_of(input int s, input int d);
    int r, c;
    r = s / COLS + ((d == 0) ? -1 : (d == 2) ? 1 : 0);
    c = s % COLS + ((d == 3) ? -1 : (d == 1) ? 1 : 0);
    if (r < 0 || r >= ROWS || c < 0 || c >= COLS) return -1;
    return r * COLS + c;
  endfunction

  function automatic bit linked(input logic [TOT-1:0] img, input int s, input int d);
    int n, k;
    n = nbr_of(s, d);
    k = kfor((s / COLS + s % COLS) % 2, d);
    if (n < 0 || k > NMUX) return 1'b0;
    return img[s*NMUX+k-1] && img[n*NMUX+k-1];
  endfunction

  function automatic void add_link(input int s, input int d);
    int n, k;
    n = nbr_of(s, d);
    k = kfor((s / COLS + s % COLS) % 2, d);
    work[s*NMUX+k-1] = 1'b1;
    if (n >= 0) work[n*NMUX+k-1] = 1'b1;
  endfunction

  task automatic shift_in(input logic [TOT-1:0] img);
    for (int i = 0; i < TOT; i++) begin
      @(negedge clk); cfg_sdi = img[i]; cfg_shift_en = 1'b1;
    end
    @(negedge clk); cfg_shift_en = 1'b0; cfg_sdi = 1'b0;
  endtask

  task automatic do_load();
    @(negedge clk); cfg_load = 1'b1;
    @(negedge clk); cfg_load = 1'b0;
    live = work;
  endtask

  // Walks a token around the loop holding start; compares with the grid model
  task automatic walk(input int start, input string req);
    bit inc [NSLOT];
    int seen [NSLOT];
    int cur, size, hops, bad;
    for (int s = 0; s < NSLOT; s++) begin inc[s] = 0; seen[s] = 0; end
    inc[start] = 1;
    for (int p = 0; p < NSLOT; p++)
      for (int s = 0; s < NSLOT; s++)
        if (inc[s])
          for (int d = 0; d < 4; d++)
            if (linked(live, s, d)) inc[nbr_of(s, d)] = 1;
    size = 0;
    for (int s = 0; s < NSLOT; s++) size += inc[s];
    cur = start; hops = 0;
    for (int h = 0; h <= NSLOT; h++) begin
      int arr_cnt, arr_slot, arr_cyc;
      arr_cnt = 0; arr_slot = -1; arr_cyc = 0;
      @(negedge clk); cell_tx[cur*W +: W] = TOKEN;
      for (int cyc = 1; cyc <= NMUX; cyc++) begin
        @(posedge clk); @(negedge clk);
        if (cyc == 1) cell_tx = '0;
        for (int s = 0; s < NSLOT; s++)
          if (cell_rx[s*W +: W] != '0) begin
            arr_cnt++; arr_slot = s; arr_cyc = cyc;
          end
      end
      // R2: one receiver, NMUX cycles after sending
      chk(arr_cnt == 1, "R2", "receivers per hop", arr_cnt, 1);
      chk(arr_cyc == NMUX, "R2", "hop latency", arr_cyc, NMUX);
      if (arr_cnt != 1) break;
      seen[arr_slot]++; hops++;
      if (arr_slot == start) break;
      cur = arr_slot;
    end
    bad = 0;
    for (int s = 0; s < NSLOT; s++) if (seen[s] != int'(inc[s])) bad++;
    chk(bad == 0, req, "slots visited other than once in the loop", bad, 0);
    chk(hops == size, req, "hops around the loop", hops, size);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures + 0);
    $finish;
  end

  initial begin
    int bad;
    rst_n = 1'b0; cfg_shift_en = 1'b0; cfg_sdi = 1'b0; cfg_load = 1'b0;
    cell_tx = '0; work = '0; live = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(cfg_sdo == 1'b0, "R1", "cfg_sdo after reset", cfg_sdo, 0);
    chk(cell_rx == '0, "R1", "cell_rx nonzero after reset", int'(cell_rx != '0), 0);
    // R1: each slot alone
    for (int s = 0; s < NSLOT; s++) walk(s, "R1");

    // R5: readback of a tree image (row 0 chain, row 2 cols 1..3 chain)
    work = '0;
    for (int c = 0; c < COLS - 1; c++) add_link(c, 1);
    for (int c = 1; c < COLS - 1; c++) add_link(2 * COLS + c, 1);
    shift_in(work);
    do_load();
    bad = 0;
    for (int i = 0; i < TOT; i++) begin
      @(negedge clk);
      if (cfg_sdo !== work[i]) bad++;
      cfg_sdi = 1'b0; cfg_shift_en = 1'b1;
    end
    @(negedge clk); cfg_shift_en = 1'b0;
    chk(bad == 0, "R5", "readback bit mismatches", bad, 0);
    // R6: chain now zero but routing kept; R8 two components
    walk(0, "R6");
    walk(2 * COLS + 3, "R8");
    walk(COLS + 1, "R8");

    // R8: comb tree spanning whole grid; shifted but not yet loaded
    work = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS - 1; c++) add_link(r * COLS + c, 1);
    for (int r = 0; r < ROWS - 1; r++) add_link(r * COLS, 2);
    shift_in(work);
    walk(1, "R6");
    do_load();
    walk(0, "R7");
    walk(7, "R8");

    // R3: one-sided bit between slots 5 and 6; real link 0-1
    work = '0;
    work[5*NMUX + kfor(0, 1) - 1] = 1'b1;
    add_link(0, 1);
    shift_in(work);
    do_load();
    walk(5, "R3");
    walk(6, "R3");
    walk(0, "R3");

    // R4: every bit set in row 0 and in slot 11; boundary stages ignored
    work = '0;
    for (int b = 0; b < COLS * NMUX; b++) work[b] = 1'b1;
    for (int k = 0; k < NMUX; k++) work[(NSLOT-1)*NMUX + k] = 1'b1;
    shift_in(work);
    do_load();
    walk(2, "R4");
    walk(NSLOT - 1, "R4");
    walk(COLS, "R4");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule